// File: doc/BRIEF.md
# DDR2 Controller Bring-Up Sequencer

This block configures a DDR2 memory controller and its PHY after reset without any processor involvement. After a start pulse it acts as a single-outstanding master on a simple register bus. It first switches on and starts the PHY delay-locked loop. It then reads the PHY status register until the loop reports lock, and writes back a forced-lock control word built from the lock code it captured.

Next it turns off automatic refresh and loads the controller's memory, precharge, refresh-interval and timing registers. It then sends each rank its DDR2 mode-register initialisation commands through the direct-command register, rank 0 first. Last, it turns automatic refresh back on, sets power-down behaviour and rewrites memory control.

A programmable read limit bounds the lock wait. If the loop never locks, the sequencer stops and raises an error flag instead of hanging. The busy, done and error flags tell the surrounding logic when the memory may be used.

Top module: `ddr2_bringup_seq`

## Requirements
- R1: After reset `busy_o`, `done_o`, `err_o` and `bus_req_o` are all 0.
- R2: The first writes go to PHY control A (offset 0x00) with 0x00101000, then PHY control B (offset 0x04) with 0x00000086, then PHY control A with 0x00101002, then PHY control A with 0x00101003.
- R3: After the fourth write the block issues only reads (`bus_we_o`=0) of PHY status (offset 0x08). It keeps re-reading while status bits [2:0] are not all ones, and stops reading on the first read where they are 111.
- R4: The next write goes to PHY control A. Its data holds status bits [13:6] in bits [31:24], 0x10 in bits [23:16] and 0x1003 in bits [15:0].
- R5: Configuration writes follow in this order. Refresh control (0x10) is written 0x0FFF2010. Memory control (0x14), config 0 (0x18) and config 1 (0x1C) take their parameter values. Precharge config (0x20) takes 0xFF000000. Refresh interval (0x24) takes the ceiling of 7.8 × CLK_MHZ (0x618 at the default 200). Row (0x28), data (0x2C) and power (0x30) timing take their parameter values.
- R6: Each rank then gets 12 writes to the direct-command register (0x34), rank 0 before rank 1. A word holds the command in [27:24], the rank in bit 20, the mode register in [18:16] and the value in [15:0]. The per-rank words, with the rank bit clear, are 0x07000000, 0x01000000, 0x00020000, 0x00030000, 0x00010400, 0x00000542, 0x01000000, 0x05000000, 0x05000000, 0x00000442, 0x00010780 and 0x00010400.
- R7: The last three writes are refresh control 0x0FF02030, power-down config (0x38) 0xFFFF00FF and memory control again, for 41 writes in total.
- R8: While `bus_req_o` is high and `bus_ready_i` low, request, direction, address and write data stay unchanged. Each cycle with both high completes exactly one transfer.
- R9: A start pulse while idle, done or in error raises `busy_o` the next cycle and clears `done_o` and `err_o`. `done_o` stays high after the sequence until the next start. A start pulse while busy has no effect on the write sequence.
- R10: If `poll_limit_i` status reads in a row return no lock, the block raises `err_o` and drops `busy_o`. It issues no further requests until the next start. A limit of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that launches the sequence |
| poll_limit_i | input | POLL_W | Maximum number of unlocked status reads |
| bus_req_o | output | 1 | Transfer request (valid) |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Register byte offset |
| bus_wdata_o | output | 32 | Write data |
| bus_ready_i | input | 1 | Target accepts the current request |
| bus_rvalid_i | input | 1 | Read data valid |
| bus_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished, held until next start |
| err_o | output | 1 | Lock timeout, held until next start |

## Verification
The hardest condition to reach is the boundary of the lock wait. The read that returns lock, or the read that exhausts the limit, must land exactly where the requirement says. The bench's target model returns a programmed number of unlocked status words, alternating 011 and 110 in the low bits, before the locked word. In another run the lock never arrives and the limit is small, so the count of reads and the absence of later writes can be checked at the ports. Stalled handshakes and a start pulse injected mid-run come from the same model, with ready held back for a chosen number of cycles.

// File: rtl/ddr2_bringup_pkg.sv
package ddr2_bringup_pkg;

  localparam int DATA_W = 32;

  // register byte offsets inside the controller window
  localparam logic [7:0] OFF_PHY_A   = 8'h00;
  localparam logic [7:0] OFF_PHY_B   = 8'h04;
  localparam logic [7:0] OFF_PHY_ST  = 8'h08;
  localparam logic [7:0] OFF_REFCTL  = 8'h10;
  localparam logic [7:0] OFF_MEMCTL  = 8'h14;
  localparam logic [7:0] OFF_CFG0    = 8'h18;
  localparam logic [7:0] OFF_CFG1    = 8'h1C;
  localparam logic [7:0] OFF_PRECH   = 8'h20;
  localparam logic [7:0] OFF_AREF    = 8'h24;
  localparam logic [7:0] OFF_TROW    = 8'h28;
  localparam logic [7:0] OFF_TDATA   = 8'h2C;
  localparam logic [7:0] OFF_TPWR    = 8'h30;
  localparam logic [7:0] OFF_DCMD    = 8'h34;
  localparam logic [7:0] OFF_PWRDN   = 8'h38;

  localparam int CMDS_PER_RANK = 12;
  localparam int FIRST_CMD_STEP = 15;  // steps before the direct commands
  localparam int TAIL_STEPS = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_RDWAIT,
    ST_DONE,
    ST_ERR
  } seq_state_e;

  typedef enum logic [3:0] {
    CMD_MODE  = 4'h0,
    CMD_PALL  = 4'h1,
    CMD_AREF  = 4'h5,
    CMD_DESEL = 4'h7
  } dcmd_e;

  // refresh interval: ceiling of 7.8 us times the clock in MHz
  function automatic logic [DATA_W-1:0] aref_count_f(input int mhz);
    return DATA_W'((mhz * 78 + 9) / 10);
  endfunction

  function automatic logic lock_seen_f(input logic [DATA_W-1:0] st);
    return &st[2:0];
  endfunction

  // forced-lock control word from the captured PHY status
  function automatic logic [DATA_W-1:0] lock_word_f(input logic [DATA_W-1:0] st);
    logic [DATA_W-1:0] code;
    code = st & 32'h0000_3FC0;
    return (code << 18) | 32'h0010_0000 | 32'h0000_1000 | 32'h0000_0003;
  endfunction

  function automatic logic [DATA_W-1:0] dcmd_word_f(input dcmd_e cmd, input logic chip,
                                                    input logic [2:0] mr,
                                                    input logic [15:0] val);
    return {4'h0, cmd, 3'b000, chip, 1'b0, mr, val};
  endfunction

  // k-th command of the per-rank DDR2 initialisation list
  function automatic logic [DATA_W-1:0] rank_cmd_f(input logic [7:0] k, input logic chip);
    case (k)
      8'd0:    return dcmd_word_f(CMD_DESEL, chip, 3'd0, 16'h0000);
      8'd1:    return dcmd_word_f(CMD_PALL,  chip, 3'd0, 16'h0000);
      8'd2:    return dcmd_word_f(CMD_MODE,  chip, 3'd2, 16'h0000);
      8'd3:    return dcmd_word_f(CMD_MODE,  chip, 3'd3, 16'h0000);
      8'd4:    return dcmd_word_f(CMD_MODE,  chip, 3'd1, 16'h0400);
      8'd5:    return dcmd_word_f(CMD_MODE,  chip, 3'd0, 16'h0542);
      8'd6:    return dcmd_word_f(CMD_PALL,  chip, 3'd0, 16'h0000);
      8'd7:    return dcmd_word_f(CMD_AREF,  chip, 3'd0, 16'h0000);
      8'd8:    return dcmd_word_f(CMD_AREF,  chip, 3'd0, 16'h0000);
      8'd9:    return dcmd_word_f(CMD_MODE,  chip, 3'd0, 16'h0442);
      8'd10:   return dcmd_word_f(CMD_MODE,  chip, 3'd1, 16'h0780);
      default: return dcmd_word_f(CMD_MODE,  chip, 3'd1, 16'h0400);
    endcase
  endfunction

endpackage

// File: rtl/ddr2_bringup_steps.sv
module ddr2_bringup_steps
  import ddr2_bringup_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_RANKS = 2,
  parameter int CLK_MHZ = 200,
  parameter logic [31:0] MEMCTL_VAL = 32'h0020_2400,
  parameter logic [31:0] MEMCFG0_VAL = 32'h20F0_1323,
  parameter logic [31:0] MEMCFG1_VAL = 32'h30F0_0312,
  parameter logic [31:0] TROW_VAL = 32'h2823_3287,
  parameter logic [31:0] TDATA_VAL = 32'h2324_0304,
  parameter logic [31:0] TPWR_VAL = 32'h09C8_0232,
  localparam int NUM_STEPS = FIRST_CMD_STEP + NUM_RANKS * CMDS_PER_RANK + TAIL_STEPS,
  localparam int STEP_W = $clog2(NUM_STEPS)
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [DATA_W-1:0] lock_word_i,
  output logic              rd_o,
  output logic              last_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int TAIL_START = FIRST_CMD_STEP + NUM_RANKS * CMDS_PER_RANK;

  logic [STEP_W-1:0] cmd_off;
  logic [STEP_W-1:0] cmd_rank;
  logic [STEP_W-1:0] cmd_k;
  logic [DATA_W-1:0] rank_word [NUM_RANKS];
  logic [DATA_W-1:0] rank_sel;

  assign cmd_off  = step_i - STEP_W'(FIRST_CMD_STEP);
  assign cmd_rank = cmd_off / STEP_W'(CMDS_PER_RANK);
  assign cmd_k    = cmd_off % STEP_W'(CMDS_PER_RANK);

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    assign rank_word[r] = rank_cmd_f(8'(cmd_k), 1'(r));
  end

  always_comb begin
    rank_sel = '0;
    for (int r = 0; r < NUM_RANKS; r++) begin
      if (cmd_rank == STEP_W'(r)) rank_sel = rank_word[r];
    end
  end

  assign last_o = (step_i == STEP_W'(NUM_STEPS - 1));

  always_comb begin
    rd_o   = 1'b0;
    addr_o = '0;
    data_o = '0;
    if (step_i < STEP_W'(FIRST_CMD_STEP)) begin
      case (step_i)
        STEP_W'(0):  begin addr_o = ADDR_W'(OFF_PHY_A);  data_o = 32'h0010_1000; end
        STEP_W'(1):  begin addr_o = ADDR_W'(OFF_PHY_B);  data_o = 32'h0000_0086; end
        STEP_W'(2):  begin addr_o = ADDR_W'(OFF_PHY_A);  data_o = 32'h0010_1002; end
        STEP_W'(3):  begin addr_o = ADDR_W'(OFF_PHY_A);  data_o = 32'h0010_1003; end
        STEP_W'(4):  begin addr_o = ADDR_W'(OFF_PHY_ST); rd_o = 1'b1; end
        STEP_W'(5):  begin addr_o = ADDR_W'(OFF_PHY_A);  data_o = lock_word_i; end
        STEP_W'(6):  begin addr_o = ADDR_W'(OFF_REFCTL); data_o = 32'h0FFF_2010; end
        STEP_W'(7):  begin addr_o = ADDR_W'(OFF_MEMCTL); data_o = MEMCTL_VAL; end
        STEP_W'(8):  begin addr_o = ADDR_W'(OFF_CFG0);   data_o = MEMCFG0_VAL; end
        STEP_W'(9):  begin addr_o = ADDR_W'(OFF_CFG1);   data_o = MEMCFG1_VAL; end
        STEP_W'(10): begin addr_o = ADDR_W'(OFF_PRECH);  data_o = 32'hFF00_0000; end
        STEP_W'(11): begin addr_o = ADDR_W'(OFF_AREF);   data_o = aref_count_f(CLK_MHZ); end
        STEP_W'(12): begin addr_o = ADDR_W'(OFF_TROW);   data_o = TROW_VAL; end
        STEP_W'(13): begin addr_o = ADDR_W'(OFF_TDATA);  data_o = TDATA_VAL; end
        default:     begin addr_o = ADDR_W'(OFF_TPWR);   data_o = TPWR_VAL; end
      endcase
    end else if (step_i < STEP_W'(TAIL_START)) begin
      addr_o = ADDR_W'(OFF_DCMD);
      data_o = rank_sel;
    end else if (step_i == STEP_W'(TAIL_START)) begin
      addr_o = ADDR_W'(OFF_REFCTL);
      data_o = 32'h0FF0_2030;
    end else if (step_i == STEP_W'(TAIL_START + 1)) begin
      addr_o = ADDR_W'(OFF_PWRDN);
      data_o = 32'hFFFF_00FF;
    end else begin
      addr_o = ADDR_W'(OFF_MEMCTL);
      data_o = MEMCTL_VAL;
    end
  end

endmodule

// File: rtl/ddr2_bringup_poll.sv
module ddr2_bringup_poll
  import ddr2_bringup_pkg::*;
#(
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              rd_done_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [POLL_W-1:0] limit_i,
  output logic              lock_hit_o,
  output logic              timeout_hit_o,
  output logic [DATA_W-1:0] lock_word_o
);

  logic [POLL_W-1:0] miss_q;
  logic [POLL_W:0]   miss_next;
  logic              locked;

  assign locked        = lock_seen_f(rdata_i);
  assign miss_next     = {1'b0, miss_q} + 1'b1;
  assign lock_hit_o    = rd_done_i && locked;
  assign timeout_hit_o = rd_done_i && !locked && (miss_next >= {1'b0, limit_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_q      <= '0;
      lock_word_o <= '0;
    end else if (clear_i) begin
      miss_q <= '0;
    end else if (rd_done_i) begin
      if (locked) lock_word_o <= lock_word_f(rdata_i);
      else        miss_q <= miss_next[POLL_W-1:0];
    end
  end

endmodule

// File: rtl/ddr2_bringup_seq.sv
module ddr2_bringup_seq
  import ddr2_bringup_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int POLL_W = 16,
  parameter int NUM_RANKS = 2,
  parameter int CLK_MHZ = 200,
  parameter logic [31:0] MEMCTL_VAL = 32'h0020_2400,
  parameter logic [31:0] MEMCFG0_VAL = 32'h20F0_1323,
  parameter logic [31:0] MEMCFG1_VAL = 32'h30F0_0312,
  parameter logic [31:0] TROW_VAL = 32'h2823_3287,
  parameter logic [31:0] TDATA_VAL = 32'h2324_0304,
  parameter logic [31:0] TPWR_VAL = 32'h09C8_0232
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [POLL_W-1:0] poll_limit_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [31:0]       bus_wdata_o,
  input  logic              bus_ready_i,
  input  logic              bus_rvalid_i,
  input  logic [31:0]       bus_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);

  localparam int NUM_STEPS = FIRST_CMD_STEP + NUM_RANKS * CMDS_PER_RANK + TAIL_STEPS;
  localparam int STEP_W = $clog2(NUM_STEPS);

  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic              step_rd;
  logic              step_last;
  logic [ADDR_W-1:0] step_addr;
  logic [DATA_W-1:0] step_data;
  logic [DATA_W-1:0] lock_word;

  // named internal events, observed by the checker
  logic launch;
  logic rd_done;
  logic lock_hit;
  logic timeout_hit;
  logic xfer;

  assign busy_o  = (state_q == ST_ISSUE) || (state_q == ST_RDWAIT);
  assign done_o  = (state_q == ST_DONE);
  assign err_o   = (state_q == ST_ERR);
  assign launch  = start_i && !busy_o;
  assign rd_done = (state_q == ST_RDWAIT) && bus_rvalid_i;
  assign xfer    = bus_req_o && bus_ready_i;

  assign bus_req_o   = (state_q == ST_ISSUE);
  assign bus_we_o    = !step_rd;
  assign bus_addr_o  = step_addr;
  assign bus_wdata_o = step_rd ? '0 : step_data;

  ddr2_bringup_steps #(
    .ADDR_W(ADDR_W), .NUM_RANKS(NUM_RANKS), .CLK_MHZ(CLK_MHZ),
    .MEMCTL_VAL(MEMCTL_VAL), .MEMCFG0_VAL(MEMCFG0_VAL), .MEMCFG1_VAL(MEMCFG1_VAL),
    .TROW_VAL(TROW_VAL), .TDATA_VAL(TDATA_VAL), .TPWR_VAL(TPWR_VAL)
  ) u_steps (
    .step_i(step_q),
    .lock_word_i(lock_word),
    .rd_o(step_rd),
    .last_o(step_last),
    .addr_o(step_addr),
    .data_o(step_data)
  );

  ddr2_bringup_poll #(.POLL_W(POLL_W)) u_poll (
    .clk(clk),
    .rst_n(rst_n),
    .clear_i(launch),
    .rd_done_i(rd_done),
    .rdata_i(bus_rdata_i),
    .limit_i(poll_limit_i),
    .lock_hit_o(lock_hit),
    .timeout_hit_o(timeout_hit),
    .lock_word_o(lock_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      case (state_q)
        ST_ISSUE: begin
          if (xfer) begin
            if (step_rd)        state_q <= ST_RDWAIT;
            else if (step_last) state_q <= ST_DONE;
            else                step_q  <= step_q + 1'b1;
          end
        end
        ST_RDWAIT: begin
          if (lock_hit) begin
            state_q <= ST_ISSUE;
            step_q  <= step_q + 1'b1;
          end else if (timeout_hit) begin
            state_q <= ST_ERR;
          end else if (rd_done) begin
            state_q <= ST_ISSUE;
          end
        end
        default: begin
          if (launch) begin
            state_q <= ST_ISSUE;
            step_q  <= '0;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/ddr2_bringup_seq_chk.sv
module ddr2_bringup_seq_chk
  import ddr2_bringup_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [31:0]       bus_wdata_o,
  input logic              bus_ready_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              lock_hit,
  input logic              timeout_hit
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_ready_i) |=> (bus_req_o && $stable(bus_we_o) && $stable(bus_addr_o) && $stable(bus_wdata_o))); // R8

  AST_READ_ONLY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_we_o) |-> (bus_addr_o == ADDR_W'(OFF_PHY_ST))); // R3

  AST_LOCK_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    lock_hit |=> (bus_req_o && bus_we_o && bus_addr_o == ADDR_W'(OFF_PHY_A) && bus_wdata_o[23:0] == 24'h10_1003)); // R4

  AST_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && !done_o && !err_o)); // R9

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o); // R9

  AST_TIMEOUT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_hit |=> (err_o && !bus_req_o)); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !start_i) |=> (err_o && !bus_req_o)); // R10

endmodule

bind ddr2_bringup_seq ddr2_bringup_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .start_i(start_i),
  .bus_req_o(bus_req_o),
  .bus_we_o(bus_we_o),
  .bus_addr_o(bus_addr_o),
  .bus_wdata_o(bus_wdata_o),
  .bus_ready_i(bus_ready_i),
  .busy_o(busy_o),
  .done_o(done_o),
  .err_o(err_o),
  .lock_hit(lock_hit),
  .timeout_hit(timeout_hit)
);

// File: tb/ddr2_bringup_seq_tb_top.sv
module ddr2_bringup_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] poll_limit_i = 16'd8;
  logic        bus_req_o, bus_we_o;
  logic [7:0]  bus_addr_o;
  logic [31:0] bus_wdata_o;
  logic        bus_ready_i = 1'b0;
  logic        bus_rvalid_i = 1'b0;
  logic [31:0] bus_rdata_i = '0;
  logic        busy_o, done_o, err_o;

  always #2 clk = ~clk;  // 250 MHz

  ddr2_bringup_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .poll_limit_i(poll_limit_i),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_ready_i(bus_ready_i), .bus_rvalid_i(bus_rvalid_i),
    .bus_rdata_i(bus_rdata_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  int checks = 0;
  int fails = 0;

  // target model state
  int          stall_cfg = 0;
  int          lock_after = 0;
  logic [31:0] lock_st = 32'h0000_1A47;
  logic [7:0]  log_a [64];
  logic [31:0] log_d [64];
  int          wr_cnt = 0;
  int          rd_cnt = 0;
  int          stab_err = 0;
  int          bad_rd_addr = 0;
  int          wcnt = 0;
  int          rd_pend = 0;
  logic [31:0] rd_val = '0;
  logic        held = 1'b0;
  logic [8:0]  h_ctl = '0;
  logic [31:0] h_data = '0;

  // expected write list
  logic [7:0]  exp_a [41];
  logic [31:0] exp_d [41];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // target: acts on falling edges only
  initial begin
    forever begin
      @(negedge clk);
      bus_rvalid_i = 1'b0;
      if (rd_pend > 0) begin
        rd_pend--;
        if (rd_pend == 0) begin
          bus_rvalid_i = 1'b1;
          bus_rdata_i  = rd_val;
        end
      end
      if (bus_ready_i) begin
        bus_ready_i = 1'b0;
        wcnt = 0;
        held = 1'b0;
      end else if (bus_req_o && held) begin
        if ({bus_we_o, bus_addr_o} != h_ctl || bus_wdata_o != h_data) stab_err++;
      end
      if (bus_req_o) begin
        if (wcnt >= stall_cfg) begin
          bus_ready_i = 1'b1;
          if (bus_we_o) begin
            if (wr_cnt < 64) begin
              log_a[wr_cnt] = bus_addr_o;
              log_d[wr_cnt] = bus_wdata_o;
            end
            wr_cnt++;
          end else begin
            if (bus_addr_o != 8'h08) bad_rd_addr++;
            // unlocked words alternate low bits 011 and 110
            if (rd_cnt >= lock_after) rd_val = lock_st;
            else rd_val = rd_cnt[0] ? 32'h0000_1A46 : 32'h0000_1A43;
            rd_cnt++;
            rd_pend = 2;
          end
        end else begin
          if (!held) begin
            h_ctl  = {bus_we_o, bus_addr_o};
            h_data = bus_wdata_o;
          end
          held = 1'b1;
          wcnt++;
        end
      end
    end
  end

  task automatic build_expected(input logic [31:0] st);
    logic [31:0] cmds [12];
    int n;
    cmds = '{32'h0700_0000, 32'h0100_0000, 32'h0002_0000, 32'h0003_0000,
             32'h0001_0400, 32'h0000_0542, 32'h0100_0000, 32'h0500_0000,
             32'h0500_0000, 32'h0000_0442, 32'h0001_0780, 32'h0001_0400};
    n = 0;
    exp_a[n] = 8'h00; exp_d[n] = 32'h0010_1000; n++;
    exp_a[n] = 8'h04; exp_d[n] = 32'h0000_0086; n++;
    exp_a[n] = 8'h00; exp_d[n] = 32'h0010_1002; n++;
    exp_a[n] = 8'h00; exp_d[n] = 32'h0010_1003; n++;
    exp_a[n] = 8'h00; exp_d[n] = {st[13:6], 8'h10, 16'h1003}; n++;
    exp_a[n] = 8'h10; exp_d[n] = 32'h0FFF_2010; n++;
    exp_a[n] = 8'h14; exp_d[n] = 32'h0020_2400; n++;
    exp_a[n] = 8'h18; exp_d[n] = 32'h20F0_1323; n++;
    exp_a[n] = 8'h1C; exp_d[n] = 32'h30F0_0312; n++;
    exp_a[n] = 8'h20; exp_d[n] = 32'hFF00_0000; n++;
    exp_a[n] = 8'h24; exp_d[n] = 32'd1560; n++;
    exp_a[n] = 8'h28; exp_d[n] = 32'h2823_3287; n++;
    exp_a[n] = 8'h2C; exp_d[n] = 32'h2324_0304; n++;
    exp_a[n] = 8'h30; exp_d[n] = 32'h09C8_0232; n++;
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < 12; k++) begin
        exp_a[n] = 8'h34;
        exp_d[n] = cmds[k] + (c * 32'h0010_0000);
        n++;
      end
    end
    exp_a[n] = 8'h10; exp_d[n] = 32'h0FF0_2030; n++;
    exp_a[n] = 8'h38; exp_d[n] = 32'hFFFF_00FF; n++;
    exp_a[n] = 8'h14; exp_d[n] = 32'h0020_2400;
  endtask

  function automatic string tag_of(input int i);
    if (i < 4) return "R2";
    if (i == 4) return "R4";
    if (i < 14) return "R5";
    if (i < 38) return "R6";
    return "R7";
  endfunction

  task automatic clear_log();
    wr_cnt = 0; rd_cnt = 0; stab_err = 0; bad_rd_addr = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_end(input string tag);
    int n = 0;
    while (!(done_o || err_o) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 5000, tag, "sequence end timeout", 32'(n), 32'd5000);
  endtask

  task automatic check_log(input string tag);
    chk(wr_cnt == 41, "R7", {tag, " write count"}, 32'(wr_cnt), 32'd41);
    for (int i = 0; i < 41 && i < wr_cnt; i++) begin
      chk(log_a[i] == exp_a[i], tag_of(i), $sformatf("%s addr #%0d", tag, i), 32'(log_a[i]), 32'(exp_a[i]));
      chk(log_d[i] == exp_d[i], tag_of(i), $sformatf("%s data #%0d", tag, i), log_d[i], exp_d[i]);
    end
  endtask

  // R1: reset state
  task automatic t_reset();
    @(negedge clk);
    chk(!busy_o && !done_o && !err_o, "R1", "flags after reset", {29'd0, busy_o, done_o, err_o}, 32'd0);
    chk(!bus_req_o, "R1", "request after reset", 32'(bus_req_o), 32'd0);
  endtask

  // R2..R7, R9: lock on third read, no stall
  task automatic t_normal();
    clear_log();
    stall_cfg = 0; lock_after = 2; lock_st = 32'h0000_1A47; poll_limit_i = 16'd8;
    build_expected(lock_st);
    pulse_start();
    chk(busy_o && !done_o, "R9", "busy after start", {30'd0, busy_o, done_o}, 32'd2);
    wait_end("R9");
    check_log("normal");
    chk(rd_cnt == 3, "R3", "status reads until lock", 32'(rd_cnt), 32'd3);
    chk(bad_rd_addr == 0, "R3", "read address", 32'(bad_rd_addr), 32'd0);
    chk(done_o && !busy_o && !err_o, "R9", "done flags", {29'd0, busy_o, done_o, err_o}, 32'd2);
    repeat (20) @(negedge clk);
    chk(done_o && !bus_req_o, "R9", "done held", {30'd0, done_o, bus_req_o}, 32'd2);
  endtask

  // R8, R4: stalled target, immediate lock, different lock code
  task automatic t_stall();
    clear_log();
    stall_cfg = 2; lock_after = 0; lock_st = 32'hFFFF_FFFF; poll_limit_i = 16'd1;
    build_expected(lock_st);
    pulse_start();
    chk(!done_o, "R9", "done cleared by start", 32'(done_o), 32'd0);
    wait_end("R8");
    check_log("stall");
    chk(stab_err == 0, "R8", "request held while stalled", 32'(stab_err), 32'd0);
    chk(rd_cnt == 1, "R3", "single read when locked at once", 32'(rd_cnt), 32'd1);
    chk(log_d[4] == 32'hFF10_1003, "R4", "lock word all ones", log_d[4], 32'hFF10_1003);
  endtask

  // R9: start pulse while busy is ignored
  task automatic t_restart_busy();
    clear_log();
    stall_cfg = 1; lock_after = 1; lock_st = 32'h0000_0FC7; poll_limit_i = 16'd4;
    build_expected(lock_st);
    pulse_start();
    repeat (30) @(negedge clk);
    chk(busy_o, "R9", "busy mid-run", 32'(busy_o), 32'd1);
    pulse_start();
    wait_end("R9");
    check_log("busy-start");
    chk(stab_err == 0, "R8", "held with stall 1", 32'(stab_err), 32'd0);
  endtask

  // R10: no lock within the limit, then recovery
  task automatic t_timeout();
    clear_log();
    stall_cfg = 0; lock_after = 1000; poll_limit_i = 16'd4;
    pulse_start();
    wait_end("R10");
    chk(err_o && !busy_o && !done_o, "R10", "error flags", {29'd0, busy_o, done_o, err_o}, 32'd1);
    chk(rd_cnt == 4, "R10", "reads before error", 32'(rd_cnt), 32'd4);
    repeat (15) @(negedge clk);
    chk(wr_cnt == 4, "R10", "no writes after error", 32'(wr_cnt), 32'd4);
    chk(err_o && !bus_req_o, "R10", "error held", {30'd0, err_o, bus_req_o}, 32'd2);
    // limit 0 behaves as 1
    clear_log();
    poll_limit_i = 16'd0;
    pulse_start();
    chk(!err_o && busy_o, "R9", "start clears error", {30'd0, err_o, busy_o}, 32'd1);
    wait_end("R10");
    chk(err_o && rd_cnt == 1, "R10", "limit 0 reads", 32'(rd_cnt), 32'd1);
    // recovery run
    clear_log();
    lock_after = 3; lock_st = 32'h0000_2AFF; poll_limit_i = 16'd4;
    build_expected(lock_st);
    pulse_start();
    wait_end("R10");
    chk(done_o && rd_cnt == 4, "R3", "lock on last allowed read", 32'(rd_cnt), 32'd4);
    check_log("recover");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_normal();
    t_stall();
    t_restart_busy();
    t_timeout();
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule